// File: doc/BRIEF.md
# Codec Event Interrupt Collector

This unit gathers the completion and fault events of an audio codec's analog section into one sticky flag register and turns them into a single interrupt line. The five event sources are gain-down done, gain-up done, ramp-down done, ramp-up done and output short-circuit. A sixth flag records every change of the debounced jack-detect level. A seventh, non-sticky bit shows that level as it is now. Software reaches the unit through the codec's internal 8-bit register path. One index holds the control register: a mask bit per flag and a two-bit field that picks how the interrupt line signals. The other index holds the flag register, and writing a 1 to a flag bit clears it.

The raw jack input is first synchronised. Its level is then accepted only after it has held steady for a set number of cycles, so short glitches leave no trace. The interrupt line is a register. Depending on the form field, it follows the unmasked flags as a high or low level, or it gives a one-cycle high or low pulse each time the unmasked flags go from none to some.

Top module: `codec_irq_unit`

## Requirements
- R1: After synchronous reset the control register reads 0x00, the flag register reads 0x00 and `irq_o` is 0.
- R2: An event input that is high at a clock edge sets its flag at that edge, and the flag stays set until it is cleared. The bit positions are: 0 gain-down done, 1 gain-up done, 2 ramp-down done, 3 ramp-up done, 4 short-circuit, 5 jack event.
- R3: A write with `reg_sel`=1 clears each flag in bits 5:0 whose data bit is 1 and leaves the others as they are. Data bits 7:6 have no effect, and writing 0x3F clears every flag.
- R4: If an event and a clear of the same flag arrive in the same cycle, the flag is set afterwards.
- R5: A write with `reg_sel`=0 stores all 8 bits in the control register, and the stored value is visible one cycle later. A 1 in bits 5:0 masks the flag at the same position from the interrupt, but the flag is still captured.
- R6: With form field (control bits 7:6) equal to 0, `irq_o` is high exactly when, one cycle earlier, at least one flag in bits 5:0 was set with its mask bit clear ("pending").
- R7: With form field 1, `irq_o` is the inverse of the pending condition one cycle earlier, so it is an active-low level.
- R8: With form field 2 (or 3), `irq_o` is high (or low) for exactly one cycle, starting one cycle after pending rises. At all other times it is low (or high).
- R9: Flag register bit 6 is the debounced jack level. It takes a new value only after the synchronised input has differed from it for `DEB_LEN` consecutive cycles. A raw pulse shorter than that leaves the bit unchanged.
- R10: Every change of the debounced jack level, rising or falling, sets flag bit 5 in the same cycle that bit 6 changes.
- R11: Flag register bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register index: 0 control, 1 flags |
| reg_wdata | input | 8 | Write data |
| evt_i | input | NUM_SRC | Event pulses, bit order as flag bits 4:0 |
| jack_i | input | 1 | Raw, asynchronous jack-detect level |
| ctrl_o | output | 8 | Control register contents |
| flag_o | output | 8 | Flag register contents |
| irq_o | output | 1 | Interrupt output |

## Verification
Flag and control results appear one edge after the stimulus. The interrupt output appears one edge later than that, because it is registered from the flag and control registers. A jack edge reaches bit 6 and flag 5 on the (2 + `DEB_LEN`)-th edge after the raw change: two synchroniser stages plus `DEB_LEN` edges of counting. The bench drives its inputs just after a falling edge and compares the outputs at the next falling edge. It does so against a cycle-accurate reference built from these latencies. The jack checks count edges to the exact one on which bit 6 must move, and check that it has not moved one edge earlier.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int REG_W = 8;
  localparam logic IDX_CTRL = 1'b0;
  localparam logic IDX_FLAG = 1'b1;

  typedef enum logic [1:0] {
    FORM_LVL_HI = 2'd0,
    FORM_LVL_LO = 2'd1,
    FORM_PLS_HI = 2'd2,
    FORM_PLS_LO = 2'd3
  } irq_form_e;
endpackage

// File: rtl/codec_jack_debounce.sv
module codec_jack_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic change_o
);
  localparam int CNT_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   level_q;
  logic                   differ;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign differ   = sync_q[SYNC_STAGES-1] != level_q;
  assign change_o = differ && (cnt_q == CNT_W'(DEB_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (change_o) begin
      cnt_q   <= '0;
      level_q <= sync_q[SYNC_STAGES-1];
    end else if (differ) begin
      cnt_q   <= cnt_q + 1'b1;
    end else begin
      cnt_q   <= '0;
    end
  end

  assign level_o = level_q;

  AST_DEB_AGREE: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> (level_q == $past(sync_q[SYNC_STAGES-1]))); // R9
endmodule

// File: rtl/codec_irq_flags.sv
module codec_irq_flags #(
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           flags_q[b] <= 1'b0;
      else if (set_i[b]) flags_q[b] <= 1'b1;
      else if (clr_i[b]) flags_q[b] <= 1'b0;
    end
  end

  assign flags_o = flags_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R4
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(flags_q)); // R2
endmodule

// File: rtl/codec_irq_out.sv
module codec_irq_out
  import codec_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  irq_form_e form_i,
  input  logic      pend_i,
  output logic      irq_o
);
  logic pend_prev_q;
  logic irq_q;
  logic rise;

  assign rise = pend_i && !pend_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_prev_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      pend_prev_q <= pend_i;
      unique case (form_i)
        FORM_LVL_HI: irq_q <= pend_i;
        FORM_LVL_LO: irq_q <= !pend_i;
        FORM_PLS_HI: irq_q <= rise;
        FORM_PLS_LO: irq_q <= !rise;
        default:     irq_q <= 1'b0;
      endcase
    end
  end

  assign irq_o = irq_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ($past(form_i) == FORM_PLS_HI && $past(form_i, 2) == FORM_PLS_HI && irq_q)
      |-> !$past(irq_q)); // R8
endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
  import codec_irq_pkg::*;
#(
  parameter int NUM_SRC     = 5,
  parameter int DEB_LEN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [7:0]         reg_wdata,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               jack_i,
  output logic [7:0]         ctrl_o,
  output logic [7:0]         flag_o,
  output logic               irq_o
);
  localparam int FLAG_W = NUM_SRC + 1;
  localparam int PAD_W  = REG_W - FLAG_W - 1;

  logic [REG_W-1:0]  ctrl_q;
  logic [FLAG_W-1:0] sticky;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] set_vec;
  logic              jack_lvl;
  logic              jack_chg;
  logic              pend;
  irq_form_e         form;

  always_ff @(posedge clk) begin
    if (rst)                              ctrl_q <= '0;
    else if (reg_wr && reg_sel == IDX_CTRL) ctrl_q <= reg_wdata;
  end

  assign clr_vec = (reg_wr && reg_sel == IDX_FLAG) ? reg_wdata[FLAG_W-1:0] : '0;
  assign set_vec = {jack_chg, evt_i};
  assign pend    = |(sticky & ~ctrl_q[FLAG_W-1:0]);
  assign form    = irq_form_e'(ctrl_q[REG_W-1:REG_W-2]);

  codec_jack_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_deb (
    .clk(clk), .rst(rst), .raw_i(jack_i), .level_o(jack_lvl), .change_o(jack_chg)
  );

  codec_irq_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .flags_o(sticky)
  );

  codec_irq_out u_out (
    .clk(clk), .rst(rst), .form_i(form), .pend_i(pend), .irq_o(irq_o)
  );

  assign ctrl_o = ctrl_q;
  if (PAD_W > 0) begin : g_pad
    assign flag_o = {{PAD_W{1'b0}}, jack_lvl, sticky};
  end else begin : g_nopad
    assign flag_o = {jack_lvl, sticky};
  end

  AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_o[7:6]) == 2'd0) |-> (irq_o == $past(|(flag_o[5:0] & ~ctrl_o[5:0])))); // R6
  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_o[7:6]) == 2'd1) |-> (irq_o != $past(|(flag_o[5:0] & ~ctrl_o[5:0])))); // R7
  AST_JACK_EVENT: assert property (@(posedge clk) disable iff (rst)
    (flag_o[6] != $past(flag_o[6])) |-> flag_o[5]); // R10
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |=> !flag_o[7]); // R11
endmodule

// File: tb/codec_irq_unit_test.sv
module codec_irq_unit_test;
  localparam int NUM_SRC = 5;
  localparam int DEB_LEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [NUM_SRC-1:0] evt_i = '0;
  logic jack_i = 1'b0;
  logic [7:0] ctrl_o, flag_o;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  codec_irq_unit #(.NUM_SRC(NUM_SRC), .DEB_LEN(DEB_LEN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .evt_i(evt_i), .jack_i(jack_i), .ctrl_o(ctrl_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // Reference state built from the requirements
  logic [7:0] m_ctrl;
  logic [5:0] m_flags;
  logic m_prev, m_irq, m_s1, m_s2, m_lvl;
  int m_cnt;

  function automatic logic irq_fn(logic [1:0] form, logic pend, logic prev);
    case (form)
      2'd0: return pend;
      2'd1: return !pend;
      2'd2: return pend && !prev;
      default: return !(pend && !prev);
    endcase
  endfunction

  function automatic logic [5:0] flags_fn(logic [5:0] cur, logic [5:0] set, logic [5:0] clr);
    return (cur & ~clr) | set;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl <= '0; m_flags <= '0; m_prev <= 0; m_irq <= 0;
      m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_cnt <= 0;
    end else begin
      logic chg;
      logic pend;
      chg  = (m_s2 != m_lvl) && (m_cnt == DEB_LEN - 1);
      pend = |(m_flags & ~m_ctrl[5:0]);
      m_s1 <= jack_i;
      m_s2 <= m_s1;
      if (chg) begin m_lvl <= m_s2; m_cnt <= 0; end
      else if (m_s2 != m_lvl) m_cnt <= m_cnt + 1;
      else m_cnt <= 0;
      m_flags <= flags_fn(m_flags, {chg, evt_i},
                          (reg_wr && reg_sel) ? reg_wdata[5:0] : 6'd0);
      if (reg_wr && !reg_sel) m_ctrl <= reg_wdata;
      m_prev <= pend;
      m_irq  <= irq_fn(m_ctrl[7:6], pend, m_prev);
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk(ctrl_o == m_ctrl, "R5 ctrl", ctrl_o, m_ctrl);
    chk(flag_o[5:0] == m_flags, "R2 flags", flag_o[5:0], m_flags);
    chk(flag_o[6] == m_lvl, "R9 jack level", flag_o[6], m_lvl);
    chk(flag_o[7] == 1'b0, "R11 bit7", flag_o[7], 0);
    chk(irq_o == m_irq, "R6 irq", irq_o, m_irq);
  endtask

  // One clock; inputs were driven after the previous falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
    reg_wr = 0; evt_i = '0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step();
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ctrl_o == 8'h00 && flag_o == 8'h00 && irq_o == 0, "R1 reset", {ctrl_o, flag_o, 7'd0, irq_o}, 0);

    // R2: ramp-up done pulse
    evt_i = 5'b01000; step();
    chk(flag_o == 8'h08, "R2 set bit3", flag_o, 8'h08);
    step(); step();
    chk(flag_o == 8'h08, "R2 sticky", flag_o, 8'h08);
    chk(irq_o == 1, "R6 level high", irq_o, 1);

    // R3: clear other bit leaves it; top bits ignored
    wr(1'b1, 8'h01);
    chk(flag_o == 8'h08, "R3 partial clear", flag_o, 8'h08);
    wr(1'b1, 8'hC8);
    chk(flag_o == 8'h00, "R3 clear bit3", flag_o, 8'h00);
    step();
    chk(irq_o == 0, "R6 level drops", irq_o, 0);
    evt_i = 5'b11111; step();
    wr(1'b1, 8'h3F);
    chk(flag_o == 8'h00, "R3 clear all", flag_o, 8'h00);

    // R4: event and clear together
    evt_i = 5'b00010; reg_wr = 1; reg_sel = 1; reg_wdata = 8'h02; step();
    chk(flag_o[1] == 1, "R4 event wins", flag_o[1], 1);

    // R5: mask bit1
    wr(1'b0, 8'h02);
    chk(ctrl_o == 8'h02, "R5 ctrl stored", ctrl_o, 8'h02);
    step();
    chk(irq_o == 0 && flag_o[1] == 1, "R5 masked", {flag_o[1], irq_o}, 2'b10);
    evt_i = 5'b00100; step();
    step();
    chk(irq_o == 1, "R5 unmasked source", irq_o, 1);
    wr(1'b1, 8'h3F);

    // R7: active-low level
    wr(1'b0, 8'h40); step();
    chk(irq_o == 1, "R7 idle high", irq_o, 1);
    evt_i = 5'b10000; step(); step();
    chk(irq_o == 0, "R7 asserted low", irq_o, 0);
    wr(1'b1, 8'h3F); step();
    chk(irq_o == 1, "R7 released", irq_o, 1);

    // R8: high pulse then low pulse
    wr(1'b0, 8'h80); step();
    evt_i = 5'b00001; step(); step();
    chk(irq_o == 1, "R8 pulse high", irq_o, 1);
    step();
    chk(irq_o == 0, "R8 pulse one cycle", irq_o, 0);
    wr(1'b1, 8'h3F);
    wr(1'b0, 8'hC0); step();
    chk(irq_o == 1, "R8 low idle", irq_o, 1);
    evt_i = 5'b00001; step(); step();
    chk(irq_o == 0, "R8 pulse low", irq_o, 0);
    step();
    chk(irq_o == 1, "R8 low pulse ends", irq_o, 1);
    wr(1'b1, 8'h3F);
    wr(1'b0, 8'h00);

    // R9/R10: jack rise exactly on edge 2+DEB_LEN
    jack_i = 1;
    for (int i = 1; i < 2 + DEB_LEN; i++) step();
    chk(flag_o[6] == 0 && flag_o[5] == 0, "R9 not yet", flag_o[6:5], 0);
    step();
    chk(flag_o[6] == 1 && flag_o[5] == 1, "R10 rise event", flag_o[6:5], 2'b11);
    wr(1'b1, 8'h20);
    // short glitch low is ignored
    jack_i = 0; step(); step(); jack_i = 1;
    for (int i = 0; i < 10; i++) step();
    chk(flag_o[6:5] == 2'b10, "R9 glitch ignored", flag_o[6:5], 2'b10);
    jack_i = 0;
    for (int i = 0; i < 2 + DEB_LEN; i++) step();
    chk(flag_o[6:5] == 2'b01, "R10 fall event", flag_o[6:5], 2'b01);

    // Random phase, checked against the reference every cycle
    for (int i = 0; i < 2000; i++) begin
      int hold;
      if (($urandom % 16) == 0) begin
        hold = 1 + ($urandom % 8);
        jack_i = ~jack_i;
      end
      evt_i = (($urandom % 4) == 0) ? NUM_SRC'($urandom) : '0;
      if (($urandom % 4) == 0) begin
        reg_wr = 1; reg_sel = 1'($urandom); reg_wdata = 8'($urandom);
      end
      step();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule